// File: doc/BRIEF.md
# Strap-addressed I2C target with retained register pointer

This block is a serial-bus target that gives an I2C controller access to four 16-bit registers held outside the block. Register selection works through a pointer. The first byte of every write transaction is loaded into the pointer. Any further bytes in that write are data for the selected register, most significant byte first. A read transaction never changes the pointer. It streams out the register that the pointer last selected, so repeated reads of one register need no extra setup.

The 7-bit bus address is formed from a fixed upper nibble and three low bits. Two three-level straps set those low bits. A pad sensor reports each strap as a 2-bit code. The block latches the decoded address once after reset, and afterwards only when the `relatch_req` input is pulsed, so strap movement at other times has no effect. SCL and SDA are brought into the system clock domain through a synchronizer. SDA is driven as an open-drain enable: `sda_oe` high pulls the line low.

Top module: `ptr_i2c_target`

## Requirements
- R1: The bus address is {1001, L} with L decoded from the straps (upper strap U, lower strap V; code 00 = low, 01 = high, 10 or 11 = floating): U,V = low,low→000, low,float→001, low,high→010, high,low→100, high,float→101, high,high→110, float,low→011, float,high→111, float,float→011.
- R2: The decoded address is captured in the first cycle after reset and again in the cycle after any `relatch_req` pulse; strap changes at other times do not alter which address is acknowledged.
- R3: START (SDA falling while SCL is high) and repeated START restart address reception from any state; STOP (SDA rising while SCL is high) returns the block to idle.
- R4: An address byte whose seven upper bits match is acknowledged. On a mismatch SDA stays released, and all bytes are ignored (not acknowledged, no writes) until the next START or STOP.
- R5: In a write (direction bit 0), the first byte after the address is acknowledged and its two low bits become the pointer. A write may end after this byte.
- R6: Later write bytes are taken in pairs, most significant byte first. After each pair, `rf_we` pulses for one cycle with `rf_idx` equal to the pointer and `rf_wdata` holding the pair. Further pairs write the same register again.
- R7: Data written while the pointer selects a read-only index (index 0 by default) is acknowledged, but `rf_we` never pulses.
- R8: A read (direction bit 1) returns the selected register's upper byte, then its lower byte, then repeats for as long as the controller acknowledges. A controller NACK releases SDA for the rest of the transaction.
- R9: The pointer keeps its value across any number of reads. A repeated START after a pointer-only write starts a read of the newly selected register.
- R10: A START or STOP arriving part way through a byte aborts that byte. The pointer is left unchanged and a half-received data pair is discarded.
- R11: `sda_oe` is low after reset, while idle and while ignoring the bus. It is asserted only in acknowledge slots of received bytes and for zero bits of read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when high |
| strap_u | input | 2 | Upper strap code from pad sensor |
| strap_v | input | 2 | Lower strap code from pad sensor |
| relatch_req | input | 1 | Pulse to capture the straps again |
| rf_idx | output | 2 | Register index, equal to the pointer |
| rf_rdata | input | 16 | Read data of the indexed register |
| rf_wdata | output | 16 | Write data for the indexed register |
| rf_we | output | 1 | One-cycle write strobe |

## Verification
Two functions can overlap in time: recapturing the strap address and comparing the incoming address byte against it. The bench first moves the straps without a relatch and confirms that the new address is refused. It then starts a transaction to that new address and pulses `relatch_req` while the address bits are still being shifted in. The byte must be acknowledged, because the recaptured address is in place before the eighth bit is evaluated. A second overlap is an abort that lands on a partially received pointer or data byte; it is judged by reading back afterwards to check that the pointer and the register contents are unchanged.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam logic [3:0] PIT_PREFIX = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } pit_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } pit_kind_e;

    // strap code: 00 low, 01 high, 1x floating
    function automatic logic [2:0] pit_decode(input logic [1:0] cu, input logic [1:0] cv);
        logic fu, hu, fv, hv;
        logic [1:0] lo2;
        fu = cu[1];
        hu = ~cu[1] & cu[0];
        fv = cv[1];
        hv = ~cv[1] & cv[0];
        if (fu)      lo2 = 2'b11;
        else if (fv) lo2 = 2'b01;
        else if (hv) lo2 = 2'b10;
        else         lo2 = 2'b00;
        return {hu | (fu & hv), lo2};
    endfunction

endpackage

// File: rtl/pit_busmon.sv
module pit_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINES = 2;  // 0: SCL, 1: SDA

    typedef struct packed {
        logic [NLINES-1:0][SYNC_STAGES-1:0] chain;
        logic [NLINES-1:0]                  prev;
    } mon_t;

    mon_t q, n;
    logic [NLINES-1:0] raw, cur;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        assign cur[g] = q.chain[g][SYNC_STAGES-1];
    end

    always_comb begin
        n = q;
        for (int i = 0; i < NLINES; i++) begin
            n.chain[i] = {q.chain[i][SYNC_STAGES-2:0], raw[i]};
        end
        n.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= n;
    end

    assign scl_rise = cur[0] & ~q.prev[0];
    assign scl_fall = ~cur[0] & q.prev[0];
    assign sda_lvl  = cur[1];
    assign start_ev = cur[0] & q.prev[0] & q.prev[1] & ~cur[1];
    assign stop_ev  = cur[0] & q.prev[0] & ~q.prev[1] & cur[1];

endmodule

// File: rtl/pit_straps.sv
module pit_straps
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_u,
    input  logic [1:0] strap_v,
    input  logic       relatch_req,
    output logic [6:0] dev_addr,
    output logic       addr_ok
);
    typedef struct packed {
        logic [2:0] low;
        logic       ok;
    } strap_t;

    strap_t q, n;

    always_comb begin
        n = q;
        if (!q.ok || relatch_req) begin
            n.low = pit_decode(strap_u, strap_v);
            n.ok  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign dev_addr = {PIT_PREFIX, q.low};
    assign addr_ok  = q.ok;

    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ok && !relatch_req) |=> $stable(q.low));

endmodule

// File: rtl/pit_engine.sv
module pit_engine
    import pit_pkg::*;
#(
    parameter int PTR_W  = 2,
    parameter int DATA_W = 16,
    parameter logic [(2**PTR_W)-1:0] RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [6:0]        dev_addr,
    input  logic              addr_ok,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  rf_idx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we
);
    localparam int NBYTES = DATA_W / 8;
    localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BI_W-1:0] LAST_IDX = BI_W'(NBYTES - 1);

    typedef struct packed {
        pit_state_e        st;
        pit_kind_e         kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              rw;
        logic [PTR_W-1:0]  ptr;
        logic [BI_W-1:0]   bidx;
        logic [DATA_W-9:0] wbuf;
        logic              oe;
        logic              mack;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } eng_t;

    eng_t q, n;

    function automatic logic [7:0] pick(input logic [DATA_W-1:0] w, input logic [BI_W-1:0] i);
        logic [7:0] b;
        b = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (BI_W'(k) == i) b = w[(NBYTES-1-k)*8 +: 8];
        end
        return b;
    endfunction

    always_comb begin
        logic [DATA_W-1:0] cat;
        logic [BI_W-1:0]   ni;
        logic [7:0]        nb;
        logic [7:0]        fb;
        n    = q;
        n.we = 1'b0;
        cat  = {q.wbuf, q.sh};
        ni   = (q.bidx == LAST_IDX) ? '0 : q.bidx + 1'b1;
        nb   = pick(rf_rdata, ni);
        fb   = pick(rf_rdata, '0);
        if (stop_ev) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else if (start_ev) begin
            n.st   = ST_RX;
            n.kind = BK_ADDR;
            n.cnt  = '0;
            n.oe   = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[6:0], sda_lvl};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        unique case (q.kind)
                            BK_ADDR: begin
                                if (addr_ok && q.sh[7:1] == dev_addr) begin
                                    n.rw = q.sh[0];
                                    n.st = ST_ACK;
                                    n.oe = 1'b1;
                                end else begin
                                    n.st = ST_SKIP;
                                end
                            end
                            BK_PTR: begin
                                n.ptr  = q.sh[PTR_W-1:0];
                                n.bidx = '0;
                                n.st   = ST_ACK;
                                n.oe   = 1'b1;
                            end
                            default: begin
                                if (q.bidx == LAST_IDX) begin
                                    n.we    = ~RO_MASK[q.ptr];
                                    n.wdata = cat;
                                    n.bidx  = '0;
                                end else begin
                                    n.wbuf = cat[DATA_W-9:0];
                                    n.bidx = q.bidx + 1'b1;
                                end
                                n.st = ST_ACK;
                                n.oe = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.kind == BK_ADDR && q.rw) begin
                            n.st   = ST_TX;
                            n.bidx = '0;
                            n.sh   = fb;
                            n.oe   = ~fb[7];
                        end else begin
                            n.st   = ST_RX;
                            n.oe   = 1'b0;
                            n.kind = (q.kind == BK_ADDR) ? BK_PTR : BK_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.st = ST_MACK;
                            n.oe = 1'b0;
                        end else begin
                            n.cnt = q.cnt + 4'd1;
                            n.sh  = {q.sh[6:0], 1'b0};
                            n.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            n.st   = ST_TX;
                            n.cnt  = '0;
                            n.bidx = ni;
                            n.sh   = nb;
                            n.oe   = ~nb[7];
                        end else begin
                            n.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe   = q.oe;
    assign rf_idx   = q.ptr;
    assign rf_wdata = q.wdata;
    assign rf_we    = q.we;

    assert_start_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (q.st == ST_RX && q.kind == BK_ADDR && q.cnt == 4'd0));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE || q.st == ST_SKIP) |-> !q.oe);

    assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    assert_ro_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> !RO_MASK[q.ptr]);

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.st == ST_RX && q.kind == BK_PTR) |=> $stable(q.ptr));

    assert_abort_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> $stable(q.ptr));

endmodule

// File: rtl/ptr_i2c_target.sv
module ptr_i2c_target #(
    parameter int PTR_W       = 2,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [(2**PTR_W)-1:0] RO_MASK = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap_u,
    input  logic [1:0]        strap_v,
    input  logic              relatch_req,
    output logic [PTR_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we
);
    logic       scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
    logic [6:0] dev_addr;
    logic       addr_ok;

    pit_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    pit_straps u_straps (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_u     (strap_u),
        .strap_v     (strap_v),
        .relatch_req (relatch_req),
        .dev_addr    (dev_addr),
        .addr_ok     (addr_ok)
    );

    pit_engine #(.PTR_W(PTR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .dev_addr (dev_addr),
        .addr_ok  (addr_ok),
        .rf_rdata (rf_rdata),
        .sda_oe   (sda_oe),
        .rf_idx   (rf_idx),
        .rf_wdata (rf_wdata),
        .rf_we    (rf_we)
    );

endmodule

// File: tb/tb_ptr_i2c_target.sv
`timescale 1ns/1ps
module tb_ptr_i2c_target;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap_u = 2'b00, strap_v = 2'b10;
    logic relatch_req = 1'b0;
    logic sda_oe, rf_we;
    logic [1:0] rf_idx;
    logic [15:0] rf_rdata, rf_wdata;
    logic [15:0] regs [4];
    logic [15:0] mdl [4];
    logic [17:0] exp_wr [$];
    int total = 0, bad = 0;
    logic done = 1'b0;
    wire sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    ptr_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_u(strap_u), .strap_v(strap_v), .relatch_req(relatch_req),
        .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_wdata(rf_wdata), .rf_we(rf_we)
    );

    assign rf_rdata = regs[rf_idx];
    always @(posedge clk) if (rf_we) regs[rf_idx] <= rf_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor for write strobes
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (exp_wr.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 unexpected write actual=%h expected=none", {rf_idx, rf_wdata});
            end else begin
                chk("R6 write item", {14'd0, rf_idx, rf_wdata}, {14'd0, exp_wr.pop_front()});
            end
        end
    end

    task automatic hold(input int n); repeat (n) @(negedge clk); endtask
    task automatic b_start();  sda_m = 1; scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q); endtask
    task automatic b_rstart(); sda_m = 1; hold(Q); scl_m = 1; hold(Q); sda_m = 0; hold(Q); scl_m = 0; hold(Q); endtask
    task automatic b_stop();   sda_m = 0; hold(Q); scl_m = 1; hold(Q); sda_m = 1; hold(Q); endtask

    task automatic clk_bit(input logic v, output logic s);
        sda_m = v; hold(Q); scl_m = 1; hold(Q/2); s = sda_line; hold(Q/2); scl_m = 0; hold(2);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        logic s;
        for (int i = 7; i > 7 - nb; i--) clk_bit(b[i], s);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp, input logic mack);
        logic s;
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        clk_bit(~mack, s);
        chk(req, {24'd0, b}, {24'd0, exp});
    endtask

    task automatic wr_data(input logic [1:0] p, input logic [15:0] w, input logic ro);
        logic a;
        if (!ro) begin exp_wr.push_back({p, w}); mdl[p] = w; end
        wr_byte(w[15:8], a); chk("R6 data ack hi", {31'd0, a}, 1);
        wr_byte(w[7:0], a);  chk("R6 data ack lo", {31'd0, a}, 1);
    endtask

    function automatic logic [2:0] exp_low(input logic [1:0] u, input logic [1:0] v);
        case ({u, v})
            4'b0000: return 3'b000; 4'b0010: return 3'b001; 4'b0001: return 3'b010;
            4'b0100: return 3'b100; 4'b0110: return 3'b101; 4'b0101: return 3'b110;
            4'b1000: return 3'b011; 4'b1001: return 3'b111; default: return 3'b011;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R3 watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a;
        regs[0] = 16'h1BC0; regs[1] = 16'h7E81; regs[2] = 16'h0000; regs[3] = 16'hFFFF;
        for (int i = 0; i < 4; i++) mdl[i] = regs[i];
        hold(5);
        rst_n = 1'b1;
        hold(3);
        chk("R11 reset oe", {31'd0, sda_oe}, 0);
        chk("R6 reset we", {31'd0, rf_we}, 0);
        // straps move after capture without relatch
        strap_u = 2'b01; strap_v = 2'b01;
        hold(4);
        b_start(); wr_byte({7'h49, 1'b0}, a); chk("R2 old addr ack", {31'd0, a}, 1); b_stop();
        b_start(); wr_byte({7'h4E, 1'b0}, a); chk("R4 mismatch nack", {31'd0, a}, 0);
        wr_byte(8'h02, a); chk("R4 ignored byte nack", {31'd0, a}, 0);
        chk("R11 released when ignoring", {31'd0, sda_oe}, 0);
        b_stop();
        // pointer + two pairs
        b_start(); wr_byte({7'h49, 1'b0}, a); wr_byte(8'h02, a); chk("R5 ptr ack", {31'd0, a}, 1);
        wr_data(2'd2, 16'hA53C, 0);
        wr_data(2'd2, 16'h1234, 0);
        b_stop(); hold(4);
        chk("R6 queue drained", exp_wr.size(), 0);
        // pointer-only write, repeated start, read stream
        b_start(); wr_byte({7'h49, 1'b0}, a); wr_byte(8'h01, a);
        b_rstart(); wr_byte({7'h49, 1'b1}, a); chk("R9 rstart read ack", {31'd0, a}, 1);
        rd_chk("R8 msb", mdl[1][15:8], 1);
        rd_chk("R8 lsb", mdl[1][7:0], 1);
        rd_chk("R8 wrap msb", mdl[1][15:8], 0);
        chk("R8 released after nack", {31'd0, sda_oe}, 0);
        b_stop();
        b_start(); wr_byte({7'h49, 1'b1}, a);
        rd_chk("R9 retained msb", mdl[1][15:8], 1);
        rd_chk("R9 retained lsb", mdl[1][7:0], 0);
        b_stop();
        b_start(); wr_byte({7'h49, 1'b0}, a); wr_byte(8'h02, a);
        b_rstart(); wr_byte({7'h49, 1'b1}, a);
        rd_chk("R9 reg2 msb", mdl[2][15:8], 1);
        rd_chk("R9 reg2 lsb", mdl[2][7:0], 0);
        b_stop();
        // read-only index
        b_start(); wr_byte({7'h49, 1'b0}, a); wr_byte(8'h00, a);
        wr_data(2'd0, 16'h55AA, 1);
        b_stop();
        b_start(); wr_byte({7'h49, 1'b1}, a);
        rd_chk("R7 ro unchanged msb", mdl[0][15:8], 1);
        rd_chk("R7 ro unchanged lsb", mdl[0][7:0], 0);
        b_stop();
        // aborts mid-byte
        b_start(); wr_byte({7'h49, 1'b0}, a); send_bits(8'h03, 4); b_stop();
        b_start(); wr_byte({7'h49, 1'b1}, a);
        rd_chk("R10 stop abort ptr kept", mdl[0][15:8], 0);
        b_stop();
        b_start(); wr_byte({7'h49, 1'b0}, a); wr_byte(8'h03, a);
        wr_byte(8'h77, a); send_bits(8'h11, 3);
        b_rstart(); wr_byte({7'h49, 1'b1}, a); chk("R3 rstart mid-byte ack", {31'd0, a}, 1);
        rd_chk("R10 half pair dropped msb", mdl[3][15:8], 1);
        rd_chk("R10 half pair dropped lsb", mdl[3][7:0], 0);
        b_stop();
        // strap map with relatch
        for (int u = 0; u < 3; u++) begin
            for (int v = 0; v < 3; v++) begin
                logic [6:0] ea;
                strap_u = 2'(u == 2 ? 2 : u); strap_v = 2'(v == 2 ? 2 : v);
                ea = {4'b1001, exp_low(strap_u, strap_v)};
                hold(2); relatch_req = 1; hold(1); relatch_req = 0; hold(2);
                b_start(); wr_byte({ea, 1'b0}, a); chk("R1 map ack", {31'd0, a}, 1); b_stop();
                b_start(); wr_byte({ea ^ 7'h01, 1'b0}, a); chk("R1 neighbour nack", {31'd0, a}, 0); b_stop();
            end
        end
        // relatch during address shifting
        strap_u = 2'b01; strap_v = 2'b00;
        hold(4);
        b_start(); wr_byte({7'h4C, 1'b0}, a); chk("R2 no relatch nack", {31'd0, a}, 0); b_stop();
        b_start();
        fork
            wr_byte({7'h4C, 1'b0}, a);
            begin hold(Q * 3); relatch_req = 1; hold(1); relatch_req = 0; end
        join
        chk("R2 relatch mid-address ack", {31'd0, a}, 1);
        b_stop();
        hold(10);
        chk("R6 no stray writes", exp_wr.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule